// File: doc/BRIEF.md
# Clock Domain Sleep Controller

This block decides when a single clock domain goes to sleep and when it wakes. A 2-bit transition-control mode, written through a simple configuration port, picks one of four policies: never start a sleep, force a sleep, force a wakeup, or let hardware decide. In the hardware-decided mode an idle monitor watches bus-interface activity and wake requests. It counts prescaled ticks in a sliding window and asks for sleep once a whole window passes with no activity. Activity or a wake request then brings the domain back.

The clock group is modelled as per-clock enable outputs. Each clock has a gate model with a fixed, parameterised settling latency. Each clock also has an activity bit that drops to 0 only once its clock is definitely gated, so the bit stays high for the whole length of a gating or ungating transition. A synchronous warm reset returns the configuration to its defaults. It does not disturb the gating state or the activity bits.

Top module: `clkdom_sleep_ctrl`

## Requirements
- R1: After cold reset, mode_o reads 3, win_o reads 4, every clk_en_o and clk_act_o bit is 1, and asleep_o is 0.
- R2: Mode encoding is 0 no-sleep, 1 software sleep, 2 software wake, 3 hardware-automatic. Writing mode 1 while awake drops every clk_en_o bit after the second rising edge counted from the write edge.
- R3: When clk_en_o falls, every clk_act_o bit stays 1 for GATE_LAT+1 cycles and then reads 0. asleep_o rises one cycle later. While asleep_o is 1, all enable and activity bits are 0.
- R4: Writing mode 2 while asleep raises every clk_en_o and clk_act_o bit and clears asleep_o after the edge following the write edge. While awake in mode 2, the domain never sleeps.
- R5: In mode 0 an awake domain never starts a sleep, however long it stays idle. An asleep domain in mode 0 stays asleep until wake_req_i is seen, and then wakes on that edge.
- R6: In mode 1 an asleep domain ignores wake_req_i and bus_act_i, and stays asleep with all activity bits 0.
- R7: In mode 3 with window W and prescale P, the enables fall exactly W*(P+1)+1 edges after the last edge on which bus_act_i or wake_req_i was 1.
- R8: In mode 3, activity seen partway through a window restarts both the window count and the prescaler. The sleep time is then measured from the newest activity.
- R9: In mode 3 an asleep domain stays asleep with no request. It wakes on the edge where bus_act_i or wake_req_i is 1.
- R10: Holding warm_rst_ni low for one edge sets the mode to 3, the window to 4 and the prescale to its default (3). The asleep state and the activity bits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_ni | input | 1 | Warm reset, active low, synchronous, configuration only |
| cfg_we_i | input | 1 | Loads mode, window and prescale on this edge |
| cfg_mode_i | input | 2 | Transition-control mode to load |
| cfg_win_i | input | WIN_W | Idle window length in ticks |
| cfg_presc_i | input | PRESC_W | Prescale value; tick period is value+1 cycles |
| bus_act_i | input | 1 | Bus-interface activity in this cycle |
| wake_req_i | input | 1 | Wakeup request |
| mode_o | output | 2 | Current mode |
| win_o | output | WIN_W | Current window length |
| clk_en_o | output | NUM_CLK | Per-clock enable request to the gates |
| clk_act_o | output | NUM_CLK | Per-clock activity: 0 only when definitely gated |
| asleep_o | output | 1 | Domain fully gated |

## Verification
The idle window is driven first with a single activity pulse and then with a second pulse in the middle of the window. The exact edge of the enable drop tells a prescaler that restarts with the window apart from a free-running one, and a window that restarts on activity apart from one that keeps counting. Each mode is then applied in both the awake and the asleep state, with and without wake and bus stimulus. This separates the mode that forces sleep from the modes that merely allow sleep. Gating is sampled edge by edge, which shows whether the activity bits outlast the enables by exactly the gate latency. A warm reset issued while asleep under a non-default configuration, followed by a timed auto-sleep, shows that only the configuration returned to its defaults.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    TC_NO_SLEEP = 2'd0,
    TC_SW_SLEEP = 2'd1,
    TC_SW_WAKE  = 2'd2,
    TC_HW_AUTO  = 2'd3
  } tc_mode_e;

  typedef enum logic [1:0] {
    DS_AWAKE    = 2'd0,
    DS_GATING   = 2'd1,
    DS_ASLEEP   = 2'd2,
    DS_UNGATING = 2'd3
  } dom_state_e;
endpackage

// File: rtl/csc_gate_slot.sv
module csc_gate_slot #(
  parameter int unsigned LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  output logic act_o,
  output logic settled_o
);
  localparam int unsigned CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

  logic          cur_q, busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        cur_q  <= ~cur_q;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (en_req_i != cur_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
    end
  end

  // activity covers the running clock and any pending or ongoing change
  assign act_o     = cur_q | busy_q | (en_req_i != cur_q);
  assign settled_o = !busy_q && (cur_q == en_req_i);
endmodule

// File: rtl/csc_idle_mon.sv
module csc_idle_mon #(
  parameter int unsigned WIN_W   = 4,
  parameter int unsigned PRESC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic               restart_i,
  input  logic [WIN_W-1:0]   win_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               idle_o
);
  logic [PRESC_W-1:0] psc_q;
  logic [WIN_W-1:0]   win_cnt_q;
  logic               tick, clear;

  assign tick  = (psc_q == presc_i);
  assign clear = !arm_i || restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q     <= '0;
      win_cnt_q <= '0;
    end else if (clear) begin
      psc_q     <= '0;
      win_cnt_q <= '0;
    end else begin
      psc_q <= tick ? '0 : psc_q + 1'b1;
      if (tick && (win_cnt_q < win_i)) win_cnt_q <= win_cnt_q + 1'b1;
    end
  end

  assign idle_o = arm_i && !restart_i && (win_cnt_q >= win_i);
endmodule

// File: rtl/clkdom_sleep_ctrl.sv
module clkdom_sleep_ctrl
  import csc_pkg::*;
#(
  parameter int unsigned NUM_CLK   = 4,
  parameter int unsigned GATE_LAT  = 3,
  parameter int unsigned WIN_W     = 4,
  parameter int unsigned PRESC_W   = 4,
  parameter int unsigned WIN_RST   = 4,
  parameter int unsigned PRESC_RST = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               warm_rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic [WIN_W-1:0]   cfg_win_i,
  input  logic [PRESC_W-1:0] cfg_presc_i,
  input  logic               bus_act_i,
  input  logic               wake_req_i,
  output logic [1:0]         mode_o,
  output logic [WIN_W-1:0]   win_o,
  output logic [NUM_CLK-1:0] clk_en_o,
  output logic [NUM_CLK-1:0] clk_act_o,
  output logic               asleep_o
);
  localparam logic [WIN_W-1:0]   WinDef   = WIN_W'(WIN_RST);
  localparam logic [PRESC_W-1:0] PrescDef = PRESC_W'(PRESC_RST);

  tc_mode_e           mode_q;
  logic [WIN_W-1:0]   win_q;
  logic [PRESC_W-1:0] presc_q;
  dom_state_e         state_q, state_d;
  logic               gate_req, all_settled, idle, restart, arm;
  logic [NUM_CLK-1:0] settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= TC_HW_AUTO;
      win_q   <= WinDef;
      presc_q <= PrescDef;
    end else if (!warm_rst_ni) begin
      mode_q  <= TC_HW_AUTO;
      win_q   <= WinDef;
      presc_q <= PrescDef;
    end else if (cfg_we_i) begin
      mode_q  <= tc_mode_e'(cfg_mode_i);
      win_q   <= cfg_win_i;
      presc_q <= cfg_presc_i;
    end
  end

  assign restart = bus_act_i || wake_req_i;
  assign arm     = warm_rst_ni && (mode_q == TC_HW_AUTO) && (state_q == DS_AWAKE);

  csc_idle_mon #(.WIN_W(WIN_W), .PRESC_W(PRESC_W)) u_idle_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .restart_i(restart),
    .win_i    (win_q),
    .presc_i  (presc_q),
    .idle_o   (idle)
  );

  assign gate_req = (state_q == DS_AWAKE) || (state_q == DS_UNGATING);

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_slot
    csc_gate_slot #(.LAT(GATE_LAT)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_req_i (gate_req),
      .act_o    (clk_act_o[i]),
      .settled_o(settled[i])
    );
  end

  assign all_settled = &settled;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DS_AWAKE:
        if (mode_q == TC_SW_SLEEP || idle) state_d = DS_GATING;
      DS_GATING:
        if (all_settled) state_d = DS_ASLEEP;
      DS_ASLEEP:
        if (mode_q == TC_SW_WAKE ||
            ((mode_q == TC_NO_SLEEP || mode_q == TC_HW_AUTO) && restart))
          state_d = DS_UNGATING;
      DS_UNGATING:
        if (all_settled) state_d = DS_AWAKE;
      default: state_d = DS_AWAKE;
    endcase
  end

  // gating state is cold-reset only; warm reset leaves it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DS_AWAKE;
    else         state_q <= state_d;
  end

  assign mode_o   = mode_q;
  assign win_o    = win_q;
  assign clk_en_o = {NUM_CLK{gate_req}};
  assign asleep_o = (state_q == DS_ASLEEP);
endmodule

// File: rtl/csc_sva.sv
module csc_sva #(
  parameter int unsigned NUM_CLK = 4,
  parameter int unsigned WIN_W   = 4,
  parameter int unsigned WIN_RST = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               warm_rst_ni,
  input logic [1:0]         mode_o,
  input logic [WIN_W-1:0]   win_o,
  input logic [NUM_CLK-1:0] clk_en_o,
  input logic [NUM_CLK-1:0] clk_act_o,
  input logic               asleep_o
);
  AST_EN_NEEDS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o & ~clk_act_o) == '0); // R3
  AST_ASLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> (clk_act_o == '0 && clk_en_o == '0)); // R3
  AST_SW_WAKE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && mode_o == 2'd2) |=> (!asleep_o && (&clk_en_o))); // R4
  AST_NO_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&clk_en_o) && (mode_o == 2'd0 || mode_o == 2'd2)) |=> (&clk_en_o)); // R5
  AST_SW_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && mode_o == 2'd1) |=> asleep_o); // R6
  AST_WARM_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm_rst_ni |=> (mode_o == 2'd3 && win_o == WIN_W'(WIN_RST))); // R10
  AST_WARM_KEEPS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warm_rst_ni && asleep_o && mode_o == 2'd1) |=> asleep_o); // R10
endmodule

bind clkdom_sleep_ctrl csc_sva #(
  .NUM_CLK(NUM_CLK), .WIN_W(WIN_W), .WIN_RST(WIN_RST)
) u_csc_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .warm_rst_ni(warm_rst_ni),
  .mode_o     (mode_o),
  .win_o      (win_o),
  .clk_en_o   (clk_en_o),
  .clk_act_o  (clk_act_o),
  .asleep_o   (asleep_o)
);

// File: tb/clkdom_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkdom_sleep_ctrl_tb_top;
  localparam int GATE_LAT = 3;
  localparam logic [3:0] ALL = 4'hF;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       warm_rst_ni = 1'b1;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_mode_i = '0;
  logic [3:0] cfg_win_i = '0;
  logic [3:0] cfg_presc_i = '0;
  logic       bus_act_i = 1'b0;
  logic       wake_req_i = 1'b0;
  logic [1:0] mode_o;
  logic [3:0] win_o;
  logic [3:0] clk_en_o;
  logic [3:0] clk_act_o;
  logic       asleep_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  clkdom_sleep_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .warm_rst_ni(warm_rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i), .cfg_win_i(cfg_win_i),
    .cfg_presc_i(cfg_presc_i), .bus_act_i(bus_act_i), .wake_req_i(wake_req_i),
    .mode_o(mode_o), .win_o(win_o), .clk_en_o(clk_en_o),
    .clk_act_o(clk_act_o), .asleep_o(asleep_o)
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [3:0] w, input logic [3:0] p);
    cfg_mode_i = m; cfg_win_i = w; cfg_presc_i = p; cfg_we_i = 1'b1;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic go_sleep(input logic [3:0] w, input logic [3:0] p);
    wr(2'd1, w, p);
    repeat (8) step();
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      n++;
      if (clk_en_o != ALL) break;
    end
  endtask

  task automatic pulse_bus();
    bus_act_i = 1'b1;
    step();
    bus_act_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 2'd3);
    chk("R1 win", win_o, 4'd4);
    chk("R1 en", clk_en_o, ALL);
    chk("R1 act", clk_act_o, ALL);
    chk("R1 asleep", asleep_o, 1'b0);
  endtask

  task automatic t_window();
    int n;
    bus_act_i = 1'b1;
    wr(2'd3, 4'd3, 4'd1);
    bus_act_i = 1'b0;
    measure(n);
    chk("R7 sleep delay W*(P+1)+1", n, 7);
    repeat (6) step();
    chk("R7 asleep after auto", asleep_o, 1'b1);
  endtask

  task automatic t_sw_wake();
    wr(2'd2, 4'd4, 4'd3);
    chk("R4 still asleep on write edge", asleep_o, 1'b1);
    step();
    chk("R4 en after wake", clk_en_o, ALL);
    chk("R4 act after wake", clk_act_o, ALL);
    chk("R4 asleep cleared", asleep_o, 1'b0);
    repeat (40) step();
    chk("R4 mode 2 stays awake", clk_en_o, ALL);
  endtask

  task automatic t_sw_sleep();
    wr(2'd1, 4'd4, 4'd3);
    chk("R2 en on write edge", clk_en_o, ALL);
    step();
    chk("R2 en dropped", clk_en_o, 4'h0);
    chk("R3 act held at drop", clk_act_o, ALL);
    repeat (GATE_LAT) step();
    chk("R3 act held to end", clk_act_o, ALL);
    chk("R3 not yet asleep", asleep_o, 1'b0);
    step();
    chk("R3 act gated", clk_act_o, 4'h0);
    chk("R3 asleep lags", asleep_o, 1'b0);
    step();
    chk("R3 asleep", asleep_o, 1'b1);
  endtask

  task automatic t_no_sleep();
    wr(2'd0, 4'd1, 4'd0);
    repeat (40) step();
    chk("R5 mode 0 stays awake", clk_en_o, ALL);
    go_sleep(4'd4, 4'd3);
    wr(2'd0, 4'd4, 4'd3);
    repeat (3) step();
    chk("R5 mode 0 no request stays asleep", asleep_o, 1'b1);
    wake_req_i = 1'b1;
    step();
    wake_req_i = 1'b0;
    chk("R5 mode 0 wake en", clk_en_o, ALL);
    chk("R5 mode 0 wake asleep", asleep_o, 1'b0);
  endtask

  task automatic t_sw_sleep_ignore();
    go_sleep(4'd4, 4'd3);
    wake_req_i = 1'b1; bus_act_i = 1'b1;
    repeat (10) step();
    chk("R6 asleep despite requests", asleep_o, 1'b1);
    chk("R6 act stays gated", clk_act_o, 4'h0);
    wake_req_i = 1'b0; bus_act_i = 1'b0;
  endtask

  task automatic t_auto_wake_restart();
    int n;
    wr(2'd3, 4'd4, 4'd3);
    repeat (5) step();
    chk("R9 asleep without request", asleep_o, 1'b1);
    pulse_bus();
    chk("R9 bus wakes en", clk_en_o, ALL);
    chk("R9 bus wakes asleep", asleep_o, 1'b0);
    repeat (6) step();
    pulse_bus();
    repeat (10) step();
    chk("R8 awake before restart", clk_en_o, ALL);
    pulse_bus();
    measure(n);
    chk("R8 restarted window delay", n, 17);
    repeat (6) step();
    wake_req_i = 1'b1;
    step();
    wake_req_i = 1'b0;
    chk("R9 wake_req wakes", clk_en_o, ALL);
  endtask

  task automatic t_warm();
    int n;
    repeat (6) step();
    go_sleep(4'd9, 4'd7);
    chk("R10 asleep before warm", asleep_o, 1'b1);
    warm_rst_ni = 1'b0;
    step();
    warm_rst_ni = 1'b1;
    chk("R10 mode default", mode_o, 2'd3);
    chk("R10 win default", win_o, 4'd4);
    chk("R10 asleep kept", asleep_o, 1'b1);
    chk("R10 act kept", clk_act_o, 4'h0);
    wake_req_i = 1'b1;
    step();
    wake_req_i = 1'b0;
    repeat (6) step();
    pulse_bus();
    measure(n);
    chk("R10 prescale default timing", n, 17);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_window();
    t_sw_wake();
    t_sw_sleep();
    repeat (2) step();
    t_sw_wake();
    t_no_sleep();
    t_sw_sleep_ignore();
    t_auto_wake_restart();
    t_warm();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule